// File: doc/BRIEF.md
# Load Data Aligner and Register Merger

This block builds the value that a load instruction writes back to its destination register. It takes the load opcode, the two low bits of the effective address, the aligned 32-bit memory word that contains the addressed data, and the current contents of the destination register. From these it picks the byte or halfword and extends it, passes a full word through, or merges a shifted memory word with the old register contents for the two partial-word loads. These partial-word loads move the word either toward the high end or toward the low end of the register.

Memory is big-endian. Byte lane k (k = address low bits) sits in bits [31-8k : 24-8k] of the word. Address generation, the memory access itself and alignment traps belong to other blocks. The result and its write enable are registered once, so they appear one clock after the inputs are presented.

Top module: `ldm_align_top`

## Requirements
- R1: Opcode 35 (full word) and opcode 48 (linked word) write the memory word unchanged.
- R2: Opcode 32 writes byte lane k, bits [31-8k : 24-8k], sign-extended to 32 bits. For example, 0x80 becomes 0xFFFFFF80.
- R3: Opcode 36 writes the same byte lane as R2 zero-extended, so bits [31:8] of the result are zero.
- R4: Opcode 33 writes a halfword sign-extended to 32 bits. The halfword is bits [31:16] when address bit 1 is 0 and bits [15:0] when it is 1. Address bit 0 is ignored. For example, 0x8000 becomes 0xFFFF8000.
- R5: Opcode 37 writes the same halfword as R4 zero-extended, so bits [31:16] of the result are zero.
- R6: Opcode 34 (left merge) with address low bits k writes (mem << 8k) OR (old AND (2^(8k) - 1)). With k = 0 this is the memory word.
- R7: Opcode 38 (right merge) with k = 1, 2 or 3 writes (mem >> 8(4-k)) OR (old AND NOT (2^(8k) - 1)).
- R8: Opcode 38 with k = 0 writes the old register value unchanged.
- R9: `wr_en` is low when `ld_valid` is low, when the opcode is not one of 32 to 38 or 48, or when `rd_idx` is 0. Whenever `wr_en` is low, `wr_data` is 0.
- R10: `wr_en` and `wr_data` show the result for the inputs sampled at the previous rising clock edge. Both are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load result is being formed this cycle |
| ld_op | input | 6 | Primary opcode of the instruction |
| addr_lo | input | 2 | Low two bits of the effective address |
| mem_word | input | 32 | Aligned memory word containing the addressed data |
| rd_old | input | 32 | Current contents of the destination register |
| rd_idx | input | 5 | Destination register number |
| wr_en | output | 1 | Register write enable, one cycle after the inputs |
| wr_data | output | 32 | Value to write, one cycle after the inputs |

## Verification
Two functions can act in the same cycle: the byte-lane merge of a partial-word load, which reads the old register value, and the suppression of the write to register 0. Both happen when a left or right merge targets register 0. The sweep applies every opcode at every address offset twice in a row, once with register 0 and once with register 17 as the destination. The suppressed case must show a low enable and zero data. The live case must show the merged value computed arithmetically from the shift-and-mask formulas. The sign-extension boundaries 0x7F/0x80 and 0x7FFF/0x8000 are also checked with fixed expected words.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OP_BYTE_S  = 6'd32;
    localparam logic [OP_W-1:0] OP_HALF_S  = 6'd33;
    localparam logic [OP_W-1:0] OP_LEFT    = 6'd34;
    localparam logic [OP_W-1:0] OP_WORD    = 6'd35;
    localparam logic [OP_W-1:0] OP_BYTE_U  = 6'd36;
    localparam logic [OP_W-1:0] OP_HALF_U  = 6'd37;
    localparam logic [OP_W-1:0] OP_RIGHT   = 6'd38;
    localparam logic [OP_W-1:0] OP_LINKED  = 6'd48;

    typedef enum logic [2:0] {
        K_NONE,
        K_WORD,
        K_BYTE_S,
        K_BYTE_U,
        K_HALF_S,
        K_HALF_U,
        K_LEFT,
        K_RIGHT
    } ld_kind_e;

endpackage

// File: rtl/ldm_decode.sv
module ldm_decode
    import ldm_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ld_kind_e        kind
);

    always_comb begin
        unique case (op)
            OP_WORD, OP_LINKED: kind = K_WORD;    // R1
            OP_BYTE_S:          kind = K_BYTE_S;  // R2
            OP_BYTE_U:          kind = K_BYTE_U;  // R3
            OP_HALF_S:          kind = K_HALF_S;  // R4
            OP_HALF_U:          kind = K_HALF_U;  // R5
            OP_LEFT:            kind = K_LEFT;    // R6
            OP_RIGHT:           kind = K_RIGHT;   // R7, R8
            default:            kind = K_NONE;    // R9
        endcase
    end

endmodule

// File: rtl/ldm_extract.sv
module ldm_extract
    import ldm_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int HALVES = BYTES / 2,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  ld_kind_e          kind,
    output logic [DATA_W-1:0] ext_val
);

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;
    logic [LANE_W-1:0] half_idx;

    assign half_idx = lane >> 1;

    // Byte lane 0 is the most significant byte (big-endian).
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (lane == LANE_W'(i)) sel_byte = word[DATA_W-1-8*i -: 8];
        end
    end

    // Halfword chosen by the upper lane bits; the lowest lane bit is ignored.
    always_comb begin
        sel_half = '0;
        for (int i = 0; i < HALVES; i++) begin
            if (half_idx == LANE_W'(i)) sel_half = word[DATA_W-1-16*i -: 16];
        end
    end

    always_comb begin
        unique case (kind)
            K_BYTE_S: ext_val = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
            K_BYTE_U: ext_val = {{(DATA_W-8){1'b0}}, sel_byte};
            K_HALF_S: ext_val = {{(DATA_W-16){sel_half[15]}}, sel_half};
            K_HALF_U: ext_val = {{(DATA_W-16){1'b0}}, sel_half};
            default:  ext_val = '0;
        endcase
    end

endmodule

// File: rtl/ldm_merge.sv
module ldm_merge #(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] old,
    input  logic [LANE_W-1:0] lane,
    input  logic              left,
    output logic [DATA_W-1:0] merged
);

    // Result lane g (0 = most significant) takes a memory lane or keeps the old lane.
    // Left merge:  memory lane g+k for g < BYTES-k, old lane otherwise.
    // Right merge: memory lane g-(BYTES-k) for g >= BYTES-k, old lane otherwise
    //              (k = 0 keeps every old lane).
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] res_lane;

        always_comb begin
            res_lane = old[DATA_W-1-8*g -: 8];
            for (int s = 0; s < BYTES; s++) begin
                if (left) begin
                    if (s == g + int'(lane)) res_lane = word[DATA_W-1-8*s -: 8];
                end else begin
                    if (s + BYTES - int'(lane) == g) res_lane = word[DATA_W-1-8*s -: 8];
                end
            end
        end

        assign merged[DATA_W-1-8*g -: 8] = res_lane;
    end

endmodule

// File: rtl/ldm_align_top.sv
module ldm_align_top
    import ldm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    localparam int LANE_W = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] rd_old,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              we;
        logic [DATA_W-1:0] data;
    } wb_t;

    ld_kind_e          kind;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] merged;
    wb_t               wb_d, wb_q;

    ldm_decode u_decode (
        .op   (ld_op),
        .kind (kind)
    );

    ldm_extract #(.DATA_W(DATA_W)) u_extract (
        .word    (mem_word),
        .lane    (addr_lo),
        .kind    (kind),
        .ext_val (ext_val)
    );

    ldm_merge #(.DATA_W(DATA_W)) u_merge (
        .word   (mem_word),
        .old    (rd_old),
        .lane   (addr_lo),
        .left   (kind == K_LEFT),
        .merged (merged)
    );

    always_comb begin
        wb_d    = '0;
        wb_d.we = ld_valid && (kind != K_NONE) && (rd_idx != '0);
        unique case (kind)
            K_WORD:                              wb_d.data = mem_word;
            K_BYTE_S, K_BYTE_U, K_HALF_S, K_HALF_U: wb_d.data = ext_val;
            K_LEFT, K_RIGHT:                     wb_d.data = merged;
            default:                             wb_d.data = '0;
        endcase
        if (!wb_d.we) wb_d.data = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wr_en   = wb_q.we;
    assign wr_data = wb_q.data;

    AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (ld_op == OP_WORD || ld_op == OP_LINKED) && rd_idx != '0)
        |=> (wr_en && wr_data == $past(mem_word))); // R1

    AST_BYTE_U_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_op == OP_BYTE_U) |=> (wr_data[DATA_W-1:8] == '0)); // R3

    AST_HALF_U_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_op == OP_HALF_U) |=> (wr_data[DATA_W-1:16] == '0)); // R5

    AST_LEFT_K0_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_op == OP_LEFT && addr_lo == '0 && rd_idx != '0)
        |=> (wr_data == $past(mem_word))); // R6

    AST_RIGHT_K0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_op == OP_RIGHT && addr_lo == '0 && rd_idx != '0)
        |=> (wr_data == $past(rd_old))); // R8

    AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0 || !ld_valid) |=> !wr_en); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (wr_data == '0)); // R9

endmodule

// File: tb/ldm_align_top_tb.sv
`timescale 1ns/1ps
module ldm_align_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [5:0]  ld_op = '0;
    logic [1:0]  addr_lo = '0;
    logic [31:0] mem_word = '0;
    logic [31:0] rd_old = '0;
    logic [4:0]  rd_idx = '0;
    logic        wr_en;
    logic [31:0] wr_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldm_align_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_op    (ld_op),
        .addr_lo  (addr_lo),
        .mem_word (mem_word),
        .rd_old   (rd_old),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    function automatic string req_tag(input logic v, input logic [5:0] op,
                                      input logic [1:0] k, input logic [4:0] rd);
        if (!v || rd == 0) return "R9";
        case (op)
            6'd35, 6'd48: return "R1";
            6'd32:        return "R2";
            6'd36:        return "R3";
            6'd33:        return "R4";
            6'd37:        return "R5";
            6'd34:        return "R6";
            6'd38:        return (k == 0) ? "R8" : "R7";
            default:      return "R9";
        endcase
    endfunction

    // Reference model built from the requirement formulas.
    function automatic logic [32:0] ref_model(input logic v, input logic [5:0] op,
                                              input logic [1:0] k, input logic [31:0] mem,
                                              input logic [31:0] old, input logic [4:0] rd);
        logic [31:0] byte_v, half_v, mask, res;
        logic        is_load;
        byte_v  = (mem >> (8 * (3 - int'(k)))) & 32'hFF;
        half_v  = (mem >> (k[1] ? 0 : 16)) & 32'hFFFF;
        mask    = (k == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - 8 * int'(k)));
        is_load = 1'b1;
        case (op)
            6'd35, 6'd48: res = mem;                                              // R1
            6'd32: res = byte_v[7]  ? (byte_v | 32'hFFFF_FF00) : byte_v;          // R2
            6'd36: res = byte_v;                                                  // R3
            6'd33: res = half_v[15] ? (half_v | 32'hFFFF_0000) : half_v;          // R4
            6'd37: res = half_v;                                                  // R5
            6'd34: res = (mem << (8 * int'(k))) | (old & mask);                   // R6
            6'd38: res = (k == 0) ? old                                           // R8
                       : ((mem >> (8 * (4 - int'(k)))) | (old & ~mask));          // R7
            default: begin res = 32'h0; is_load = 1'b0; end
        endcase
        if (!(v && is_load && rd != 0)) return {1'b0, 32'h0};                    // R9
        return {1'b1, res};
    endfunction

    task automatic check(input string tag, input logic exp_we, input logic [31:0] exp_d);
        n_vec++;
        if (wr_en !== exp_we || wr_data !== exp_d) begin
            n_bad++;
            $display("FAIL %s: got en=%0b data=%08h, expected en=%0b data=%08h (op=%0d k=%0d rd=%0d)",
                     tag, wr_en, wr_data, exp_we, exp_d, ld_op, addr_lo, rd_idx);
        end
    endtask

    // R10: inputs set at the falling edge, result sampled just after the next rising edge.
    task automatic apply(input logic v, input logic [5:0] op, input logic [1:0] k,
                         input logic [31:0] mem, input logic [31:0] old, input logic [4:0] rd);
        logic [32:0] e;
        @(negedge clk);
        ld_valid = v; ld_op = op; addr_lo = k; mem_word = mem; rd_old = old; rd_idx = rd;
        e = ref_model(v, op, k, mem, old, rd);
        @(posedge clk);
        #1;
        check(req_tag(v, op, k, rd), e[32], e[31:0]);
    endtask

    task automatic apply_fixed(input string tag, input logic [5:0] op, input logic [1:0] k,
                               input logic [31:0] mem, input logic [31:0] old,
                               input logic [31:0] exp_d);
        @(negedge clk);
        ld_valid = 1'b1; ld_op = op; addr_lo = k; mem_word = mem; rd_old = old; rd_idx = 5'd9;
        @(posedge clk);
        #1;
        check(tag, 1'b1, exp_d);
    endtask

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h80FF_7F01; pats[1] = 32'h1234_5678; pats[2] = 32'h7F80_8000;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h0000_0000; pats[5] = 32'h8000_7FFF;

        // Reset state, R10
        repeat (3) @(posedge clk);
        #1;
        check("R10", 1'b0, 32'h0);
        @(negedge clk);
        ld_valid = 1'b1; ld_op = 6'd35; mem_word = 32'hDEAD_BEEF; rd_idx = 5'd4;
        @(posedge clk);
        #1;
        check("R10", 1'b0, 32'h0);  // still in reset
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R10", 1'b1, 32'hDEAD_BEEF);

        // Sign-extension boundaries, R2 R3 R4 R5
        apply_fixed("R2", 6'd32, 2'd1, 32'h0080_0000, 32'h0, 32'hFFFF_FF80);
        apply_fixed("R2", 6'd32, 2'd1, 32'h007F_0000, 32'h0, 32'h0000_007F);
        apply_fixed("R3", 6'd36, 2'd3, 32'h0000_0080, 32'h0, 32'h0000_0080);
        apply_fixed("R4", 6'd33, 2'd2, 32'h1234_8000, 32'h0, 32'hFFFF_8000);
        apply_fixed("R4", 6'd33, 2'd1, 32'h7FFF_0000, 32'h0, 32'h0000_7FFF);
        apply_fixed("R5", 6'd37, 2'd0, 32'h8000_1234, 32'h0, 32'h0000_8000);
        // Partial-word merges with fixed expectations, R6 R7 R8
        apply_fixed("R6", 6'd34, 2'd2, 32'h1122_3344, 32'hAABB_CCDD, 32'h3344_CCDD);
        apply_fixed("R7", 6'd38, 2'd1, 32'h1122_3344, 32'hAABB_CCDD, 32'hAABB_CC11);
        apply_fixed("R7", 6'd38, 2'd3, 32'h1122_3344, 32'hAABB_CCDD, 32'hAA11_2233);
        apply_fixed("R8", 6'd38, 2'd0, 32'h1122_3344, 32'hAABB_CCDD, 32'hAABB_CCDD);

        // Idle cycle, R9
        apply(1'b0, 6'd35, 2'd0, 32'h1234_5678, 32'h0, 5'd3);

        // Exhaustive sweep of opcode, offset, pattern and destination
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 4; k++) begin
                for (int p = 0; p < 6; p++) begin
                    apply(1'b1, 6'(op), 2'(k), pats[p], pats[5 - p] ^ 32'hA5C3_5A3C, 5'd0);
                    apply(1'b1, 6'(op), 2'(k), pats[p], pats[5 - p] ^ 32'hA5C3_5A3C, 5'd17);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL R10: watchdog expired, got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule